// File: doc/BRIEF.md
# Lane-Parallel Shift-Round-Saturate Unit

This block moves data between a wide accumulator vector and a narrower data vector. The accumulator word has eight independent signed lanes of 48 bits. Each lane is a 32-bit product with 16 guard bits on top, so as many as 2^16 products can be summed in it before it overflows. The data vector has eight signed 32-bit lanes.

On the down path, each accumulator lane is shifted right arithmetically by a programmable amount. It is then either rounded or truncated, and either saturated or wrapped to 32 bits. On the up path, each 32-bit lane is sign-extended to 48 bits and shifted left.

Two sticky mode bits, round and saturate, are set and cleared by strobes. They act only on the down path. A transfer is offered with `valid_i` and its result appears one clock later, marked by `valid_o`.

Top module: `srs_unit`

## Requirements
- R1: After reset `valid_o` is 0, `vec_o` and `acc_o` are all zero, and both round and saturate modes are off.
- R2: An accepted transfer (`valid_i`=1 at a rising edge) gives `valid_o`=1 in the following cycle. A cycle with `valid_i`=0 gives `valid_o`=0 in the following cycle.
- R3: Lane packing is fixed. Accumulator lane k is `acc[48k+47:48k]` and vector lane k is `vec[32k+31:32k]`. `dir_up_i`=0 selects the down path. With both modes off, the down path puts into vector lane k the low 32 bits of the signed accumulator lane k shifted right arithmetically by the shift amount. A shift of zero is allowed.
- R4: Shift values 48 to 63 behave exactly as 47, on both paths.
- R5: A set strobe turns its mode on and a clear strobe turns it off. When both arrive in the same cycle, clear wins. A new mode applies from the next accepted transfer onwards. A transfer accepted in the same cycle as the strobe still uses the old mode.
- R6: With saturation on, a down result above 2^31-1 becomes 0x7FFFFFFF and a result below -2^31 becomes 0x80000000. A non-negative lane never turns into a negative result.
- R7: With rounding on and a non-zero shift s, 2^(s-1) is added to the lane before the shift, using full precision with no wrap. With s=0, rounding changes nothing.
- R8: `dir_up_i`=1 selects the up path. Accumulator lane k of `acc_o` becomes vector lane k sign-extended to 48 bits, shifted left by the shift amount, keeping the low 48 bits. Round and saturate have no effect on this path, and the shifted-in low bits are zero.
- R9: `vec_o` changes only on accepted down transfers and `acc_o` changes only on accepted up transfers. Otherwise both hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Transfer request |
| dir_up_i | input | 1 | 1: vector to accumulator, 0: accumulator to vector |
| shift_i | input | 6 | Shift amount, clamped to 47 |
| acc_i | input | 384 | Eight 48-bit accumulator lanes for the down path |
| vec_i | input | 256 | Eight 32-bit lanes for the up path |
| rnd_set_i | input | 1 | Turn rounding on |
| rnd_clr_i | input | 1 | Turn rounding off |
| sat_set_i | input | 1 | Turn saturation on |
| sat_clr_i | input | 1 | Turn saturation off |
| valid_o | output | 1 | Result valid |
| vec_o | output | 256 | Down-path result |
| acc_o | output | 384 | Up-path result |

## Verification
The bench targets the cases that are easiest to get wrong:
- **Rounding bias at the top of the range.** A lane of 0x7FFF_FFFF_FFFF with rounding on would wrap negative if the bias were added without an extra bit. Saturation would then clamp it to the wrong end.
- **Sign handling.** A logical shift in place of an arithmetic one, or up-conversion without sign extension, corrupts every negative lane.
- **Shift clamp.** Shift values above 47 check the clamp. A shift of zero checks that rounding does not add a stray bias.
- **Mode timing.** Set and clear strobes are issued together with a transfer, and set and clear are issued together. This catches a mode that applies one cycle early, or a set that wins over a clear.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam int unsigned NUM_LANES = 8;
  localparam int unsigned ACC_LANE_W = 48;
  localparam int unsigned VEC_LANE_W = 32;
  localparam int unsigned SHAMT_W = 6;

  typedef struct packed {
    logic rnd;
    logic sat;
  } srs_mode_t;
endpackage

// File: rtl/srs_mode_bit.sv
module srs_mode_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mode_o <= 1'b0;
    else if (clr_i) mode_o <= 1'b0;
    else if (set_i) mode_o <= 1'b1;
  end

  a_r5_clr_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && clr_i) |=> !mode_o);
  a_r5_set_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> mode_o);
endmodule

// File: rtl/srs_down_lane.sv
module srs_down_lane #(
  parameter int unsigned ACC_W = 48,
  parameter int unsigned VEC_W = 32,
  parameter int unsigned SH_W  = 6
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [SH_W-1:0]  shamt_i,
  input  logic             rnd_i,
  input  logic             sat_i,
  output logic [VEC_W-1:0] res_o
);
  localparam int unsigned EXT_W = ACC_W + 1;  // headroom for the rounding bias

  logic signed [EXT_W-1:0] ext, bias, sum, shifted;
  logic pos_ovf, neg_ovf;

  always_comb begin
    ext     = {acc_i[ACC_W-1], acc_i};
    bias    = (rnd_i && shamt_i != '0) ? (EXT_W'(1) << (shamt_i - SH_W'(1))) : '0;
    sum     = ext + bias;
    shifted = sum >>> shamt_i;
    pos_ovf = !shifted[EXT_W-1] && (|shifted[EXT_W-2:VEC_W-1]);
    neg_ovf = shifted[EXT_W-1] && !(&shifted[EXT_W-2:VEC_W-1]);
    if (sat_i && pos_ovf)      res_o = {1'b0, {(VEC_W-1){1'b1}}};
    else if (sat_i && neg_ovf) res_o = {1'b1, {(VEC_W-1){1'b0}}};
    else                       res_o = shifted[VEC_W-1:0];
  end

  always_comb begin
    if (sat_i && acc_i[ACC_W-1] == 1'b0)
      a_r6_nonneg_stays: assert (res_o[VEC_W-1] == 1'b0);
  end
endmodule

// File: rtl/srs_up_lane.sv
module srs_up_lane #(
  parameter int unsigned ACC_W = 48,
  parameter int unsigned VEC_W = 32,
  parameter int unsigned SH_W  = 6
) (
  input  logic [VEC_W-1:0] vec_i,
  input  logic [SH_W-1:0]  shamt_i,
  output logic [ACC_W-1:0] res_o
);
  logic [ACC_W-1:0] ext, low_mask;

  always_comb begin
    ext      = {{(ACC_W-VEC_W){vec_i[VEC_W-1]}}, vec_i};
    res_o    = ext << shamt_i;
    low_mask = (ACC_W'(1) << shamt_i) - ACC_W'(1);
  end

  always_comb begin
    a_r8_low_zero: assert ((res_o & low_mask) == '0);
  end
endmodule

// File: rtl/srs_unit.sv
module srs_unit #(
  parameter int unsigned LANES   = srs_pkg::NUM_LANES,
  parameter int unsigned ACC_W   = srs_pkg::ACC_LANE_W,
  parameter int unsigned VEC_W   = srs_pkg::VEC_LANE_W,
  parameter int unsigned SHIFT_W = srs_pkg::SHAMT_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic                   dir_up_i,
  input  logic [SHIFT_W-1:0]     shift_i,
  input  logic [LANES*ACC_W-1:0] acc_i,
  input  logic [LANES*VEC_W-1:0] vec_i,
  input  logic                   rnd_set_i,
  input  logic                   rnd_clr_i,
  input  logic                   sat_set_i,
  input  logic                   sat_clr_i,
  output logic                   valid_o,
  output logic [LANES*VEC_W-1:0] vec_o,
  output logic [LANES*ACC_W-1:0] acc_o
);
  localparam int unsigned MAX_SH = ACC_W - 1;

  srs_pkg::srs_mode_t mode;
  logic [SHIFT_W-1:0] shamt;
  logic [LANES*VEC_W-1:0] vec_d;
  logic [LANES*ACC_W-1:0] acc_d;

  srs_mode_bit i_rnd (.clk_i, .rst_ni, .set_i(rnd_set_i), .clr_i(rnd_clr_i), .mode_o(mode.rnd));
  srs_mode_bit i_sat (.clk_i, .rst_ni, .set_i(sat_set_i), .clr_i(sat_clr_i), .mode_o(mode.sat));

  assign shamt = (shift_i > SHIFT_W'(MAX_SH)) ? SHIFT_W'(MAX_SH) : shift_i;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    srs_down_lane #(.ACC_W(ACC_W), .VEC_W(VEC_W), .SH_W(SHIFT_W)) i_down (
      .acc_i  (acc_i[k*ACC_W +: ACC_W]),
      .shamt_i(shamt),
      .rnd_i  (mode.rnd),
      .sat_i  (mode.sat),
      .res_o  (vec_d[k*VEC_W +: VEC_W])
    );
    srs_up_lane #(.ACC_W(ACC_W), .VEC_W(VEC_W), .SH_W(SHIFT_W)) i_up (
      .vec_i  (vec_i[k*VEC_W +: VEC_W]),
      .shamt_i(shamt),
      .res_o  (acc_d[k*ACC_W +: ACC_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      vec_o   <= '0;
      acc_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i && !dir_up_i) vec_o <= vec_d;
      if (valid_i && dir_up_i)  acc_o <= acc_d;
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(vec_o) && $stable(acc_o)));
  a_r8_up_keeps_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dir_up_i) |=> $stable(vec_o));
  a_r9_down_keeps_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dir_up_i) |=> $stable(acc_o));
endmodule

// File: tb/test_srs_unit.sv
module test_srs_unit;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic valid_i = 1'b0, dir_up_i = 1'b0;
  logic [5:0] shift_i = '0;
  logic [383:0] acc_i = '0;
  logic [255:0] vec_i = '0;
  logic rnd_set_i = 0, rnd_clr_i = 0, sat_set_i = 0, sat_clr_i = 0;
  logic valid_o;
  logic [255:0] vec_o;
  logic [383:0] acc_o;

  int checks = 0, failures = 0;
  bit done = 0;
  bit rnd_m = 0, sat_m = 0;
  logic [255:0] exp_vec = '0;
  logic [383:0] exp_acc = '0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  srs_unit i_srs_unit (.*);

  function automatic logic [31:0] down_ref(logic [47:0] a, logic [5:0] sh, bit rnd, bit sat);
    longint x, y;
    int s;
    s = (sh > 47) ? 47 : int'(sh);
    x = longint'($signed(a));
    if (rnd && s > 0) x = x + (longint'(1) <<< (s - 1));
    y = x >>> s;
    if (sat && y > 64'sd2147483647) y = 64'sd2147483647;
    if (sat && y < -64'sd2147483648) y = -64'sd2147483648;
    return y[31:0];
  endfunction

  function automatic logic [47:0] up_ref(logic [31:0] v, logic [5:0] sh);
    longint x;
    int s;
    s = (sh > 47) ? 47 : int'(sh);
    x = longint'($signed(v)) <<< s;
    return x[47:0];
  endfunction

  task automatic check(input string req, input logic [383:0] act, input logic [383:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input string req, input bit up, input logic [5:0] sh,
                      input logic [383:0] a, input logic [255:0] v,
                      input bit rs, input bit rc, input bit ss, input bit sc);
    valid_i = 1; dir_up_i = up; shift_i = sh; acc_i = a; vec_i = v;
    rnd_set_i = rs; rnd_clr_i = rc; sat_set_i = ss; sat_clr_i = sc;
    for (int k = 0; k < 8; k++) begin
      if (up) exp_acc[48*k +: 48] = up_ref(v[32*k +: 32], sh);
      else    exp_vec[32*k +: 32] = down_ref(a[48*k +: 48], sh, rnd_m, sat_m);
    end
    if (rc) rnd_m = 0; else if (rs) rnd_m = 1;
    if (sc) sat_m = 0; else if (ss) sat_m = 1;
    @(negedge clk_i);
    check({req, " valid"}, {383'd0, valid_o}, 384'd1);
    check({req, " vec"}, {128'd0, vec_o}, {128'd0, exp_vec});
    check({req, " acc"}, acc_o, exp_acc);
    valid_i = 0; rnd_set_i = 0; rnd_clr_i = 0; sat_set_i = 0; sat_clr_i = 0;
  endtask

  function automatic logic [383:0] fill_acc(logic [47:0] l);
    logic [383:0] r;
    for (int k = 0; k < 8; k++) r[48*k +: 48] = l;
    return r;
  endfunction

  function automatic logic [47:0] rand_lane();
    logic [47:0] l;
    l = {$urandom, $urandom} ;
    case ($urandom % 4)
      0: ;
      1: l = {{16{l[31]}}, l[31:0]};
      2: l = l[0] ? 48'h7FFF_FFFF_FFFF : 48'h8000_0000_0000;
      default: l = {{8{l[39]}}, l[39:0]};
    endcase
    return l;
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [383:0] a;
    logic [255:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 valid", {383'd0, valid_o}, 384'd0);
    check("R1 vec", {128'd0, vec_o}, 384'd0);
    check("R1 acc", acc_o, 384'd0);
    rst_ni = 1;
    @(negedge clk_i);
    // R3 truncation, shift 0 and arithmetic shift of negatives
    xfer("R3 shift0", 0, 6'd0, fill_acc(48'h1234_5678_9ABC), '0, 0, 0, 0, 0);
    xfer("R3 neg", 0, 6'd4, fill_acc(-48'sd256), '0, 0, 0, 0, 0);
    // R4 clamp
    xfer("R4 down63", 0, 6'd63, fill_acc(48'h8000_0000_0000), '0, 0, 0, 0, 0);
    xfer("R4 down48", 0, 6'd48, fill_acc(48'h4000_0000_0000), '0, 0, 0, 0, 0);
    // R5 set in same cycle as transfer still truncates; R7 next one rounds
    xfer("R5 old mode", 0, 6'd4, fill_acc(48'h18), '0, 1, 0, 0, 0);
    xfer("R7 round pos", 0, 6'd4, fill_acc(48'h18), '0, 0, 0, 0, 0);
    xfer("R7 round neg", 0, 6'd4, fill_acc(-48'sd24), '0, 0, 0, 0, 0);
    xfer("R7 shift0", 0, 6'd0, fill_acc(48'h5), '0, 0, 0, 1, 0);
    // R6 saturation, including top-of-range rounding
    xfer("R6 pos", 0, 6'd0, fill_acc(48'h0000_8000_0000), '0, 0, 0, 0, 0);
    xfer("R6 neg", 0, 6'd0, fill_acc(48'hFFFF_7FFF_FFFF), '0, 0, 0, 0, 0);
    xfer("R6 max rnd", 0, 6'd1, fill_acc(48'h7FFF_FFFF_FFFF), '0, 0, 0, 0, 0);
    // R5 set and clear together: clear wins
    xfer("R5 both", 0, 6'd0, fill_acc(48'h0001_0000_0001), '0, 1, 1, 1, 1);
    xfer("R5 cleared", 0, 6'd0, fill_acc(48'h0001_0000_0001), '0, 0, 0, 0, 0);
    // R8 up path, modes set but without effect
    xfer("R8 up16", 1, 6'd16, '0, {8{32'h8000_0001}}, 1, 0, 1, 0);
    xfer("R8 up63", 1, 6'd63, '0, {8{32'h0000_0003}}, 0, 0, 0, 0);
    // R9 idle holds outputs
    @(negedge clk_i);
    check("R9 idle valid", {383'd0, valid_o}, 384'd0);
    check("R9 idle vec", {128'd0, vec_o}, {128'd0, exp_vec});
    check("R9 idle acc", acc_o, exp_acc);
    // random mix
    for (int n = 0; n < 400; n++) begin
      for (int k = 0; k < 8; k++) begin
        a[48*k +: 48] = rand_lane();
        v[32*k +: 32] = $urandom;
      end
      xfer("R3 R6 R7 R8 random", $urandom % 3 == 0, 6'($urandom), a, v,
           $urandom % 5 == 0, $urandom % 5 == 0, $urandom % 5 == 0, $urandom % 5 == 0);
      if ($urandom % 8 == 0) begin
        @(negedge clk_i);
        check("R2 idle valid", {383'd0, valid_o}, 384'd0);
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule